// File: doc/BRIEF.md
# Three-share masked GF(2^128) multiplier

This block multiplies two secret field elements of GF(2^128) without ever combining the shares of either operand. Each operand is presented as three Boolean shares whose XOR is its true value, and the product is returned as three shares whose XOR is the true product. The field is the one used for authentication tags in counter-mode authenticated encryption: reduction by x^128 + x^7 + x^2 + x + 1, with bit 127 of a vector holding the coefficient of x^0 and bit 0 holding the coefficient of x^127.

Internally, a nonlinear layer forms all nine cross-share products x_i·y_j in parallel and stores them in a register bank together with the random masks. A linear layer then XORs three registered products per output share and adds a fresh mask, and the result is registered at the output. A new operand pair may be accepted on every clock cycle; every result appears exactly two cycles later. The caller supplies 256 fresh random bits with every accepted operation.

Top module: `gf128_masked_mult`

## Requirements
- R1: While reset is held and on the first cycle after it, outValid is low and all three product shares read zero.
- R2: For every accepted operation, pShare0 ^ pShare1 ^ pShare2 equals (xShare0^xShare1^xShare2)·(yShare0^yShare1^yShare2) in GF(2^128), bit 127 being the x^0 coefficient and the reduction polynomial x^128 + x^7 + x^2 + x + 1.
- R3: outValid rises exactly two rising clock edges after the edge that samples inValid high, and is low in every cycle that does not carry such a result.
- R4: With inValid high on consecutive cycles, one result emerges per cycle in the order of acceptance, with none dropped.
- R5: Writing P_ij for the field product of xShare i and yShare j, r0 for rnd[127:0] and r1 for rnd[255:128], the shares are pShare0 = P00^P01^P10^r0, pShare1 = P11^P12^P21^r1 and pShare2 = P22^P20^P02^r0^r1, all taken from the same accepted operation.
- R6: When no result is delivered, the three product shares keep the values of the last delivered result.
- R7: A recombined x of zero yields a recombined product of zero, and a recombined x of one (only bit 127 set) yields the recombined y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand pair and masks valid this cycle |
| xShare0 | input | 128 | First share of operand x |
| xShare1 | input | 128 | Second share of operand x |
| xShare2 | input | 128 | Third share of operand x |
| yShare0 | input | 128 | First share of operand y |
| yShare1 | input | 128 | Second share of operand y |
| yShare2 | input | 128 | Third share of operand y |
| rnd | input | 256 | Fresh masks: r0 in the low half, r1 in the high half |
| outValid | output | 1 | Product shares carry a new result |
| pShare0 | output | 128 | First share of the product |
| pShare1 | output | 128 | Second share of the product |
| pShare2 | output | 128 | Third share of the product |

## Verification
The bench builds the block with its default 128-bit width and the tag-field reduction constant, so every result can be compared against a reference multiplier that works in plain polynomial order and reduces a 255-bit carry-less product, a method unrelated to the shift-and-add cells. At this width random shares exercise the reduction path on almost every operation, and dedicated phases reach the zero and identity operands, an all-ones operand, unbroken valid streams and long idle gaps where the hold behaviour of the output shares is visible.

// File: rtl/gf128_masked_pkg.sv
package gf128_masked_pkg;

  localparam int NUM_SHARES = 3;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic loadProd;
    logic loadOut;
  } mulStrobes_t;

endpackage

// File: rtl/gf128_mul_cell.sv
// Combinational shift-and-add multiplier in the reflected bit order.
module gf128_mul_cell #(
  parameter int WIDTH = 128,
  parameter logic [WIDTH-1:0] REDUCE = {8'hE1, {(WIDTH-8){1'b0}}}
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] prod
);

  logic [WIDTH-1:0] acc;
  logic [WIDTH-1:0] walk;

  always_comb begin
    acc  = '0;
    walk = opB;
    for (int i = 0; i < WIDTH; i++) begin
      if (opA[WIDTH-1-i]) acc = acc ^ walk;
      if (walk[0]) walk = (walk >> 1) ^ REDUCE;
      else         walk = walk >> 1;
    end
  end

  assign prod = acc;

endmodule

// File: rtl/gf128_masked_ctrl.sv
module gf128_masked_ctrl
  import gf128_masked_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output mulStrobes_t strobes,
  output logic        outValid
);

  logic midValid;
  logic resValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      midValid <= 1'b0;
      resValid <= 1'b0;
    end else begin
      midValid <= inValid;
      resValid <= midValid;
    end
  end

  assign strobes.loadProd = inValid & ~rst;
  assign strobes.loadOut  = midValid;
  assign outValid         = resValid;

  // R3: a sampled operation reaches the output exactly two edges later
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    inValid |=> ##1 outValid);

  // R3: no result appears without an operation two edges before it
  p_no_phantom_r3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(midValid));

  // R4: a two-cycle valid stream yields two consecutive results
  p_stream_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && midValid) |=> (midValid && outValid));

endmodule

// File: rtl/gf128_masked_dp.sv
module gf128_masked_dp
  import gf128_masked_pkg::*;
#(
  parameter int WIDTH = 128,
  parameter logic [WIDTH-1:0] REDUCE = {8'hE1, {(WIDTH-8){1'b0}}},
  localparam int RND_W = 2 * WIDTH
) (
  input  logic                             clk,
  input  logic                             rst,
  input  mulStrobes_t                      strobes,
  input  logic [NUM_SHARES-1:0][WIDTH-1:0] xSh,
  input  logic [NUM_SHARES-1:0][WIDTH-1:0] ySh,
  input  logic [RND_W-1:0]                 rnd,
  output logic [NUM_SHARES-1:0][WIDTH-1:0] pSh
);

  // Nonlinear layer: every cross-share product.
  logic [NUM_SHARES-1:0][NUM_SHARES-1:0][WIDTH-1:0] crossProd;
  logic [NUM_SHARES-1:0][NUM_SHARES-1:0][WIDTH-1:0] prodReg;
  logic [NUM_SHARES-1:0][WIDTH-1:0]                 maskReg;
  logic [NUM_SHARES-1:0][WIDTH-1:0]                 compressed;
  logic [NUM_SHARES-1:0][WIDTH-1:0]                 outReg;

  for (genvar i = 0; i < NUM_SHARES; i++) begin : g_row
    for (genvar j = 0; j < NUM_SHARES; j++) begin : g_col
      gf128_mul_cell #(.WIDTH(WIDTH), .REDUCE(REDUCE)) u_cell (
        .opA (xSh[i]),
        .opB (ySh[j]),
        .prod(crossProd[i][j])
      );
    end
  end

  // Register boundary between the layers; masks travel alongside.
  always_ff @(posedge clk) begin
    if (rst) begin
      prodReg <= '0;
      maskReg <= '0;
    end else if (strobes.loadProd) begin
      prodReg    <= crossProd;
      maskReg[0] <= rnd[WIDTH-1:0];
      maskReg[1] <= rnd[RND_W-1:WIDTH];
      maskReg[2] <= rnd[WIDTH-1:0] ^ rnd[RND_W-1:WIDTH];
    end
  end

  // Linear layer: share k takes products (k,k), (k,k+1), (k+1,k).
  for (genvar k = 0; k < NUM_SHARES; k++) begin : g_comp
    localparam int NXT = (k + 1) % NUM_SHARES;
    assign compressed[k] = prodReg[k][k] ^ prodReg[k][NXT]
                         ^ prodReg[NXT][k] ^ maskReg[k];
  end

  always_ff @(posedge clk) begin
    if (rst)                  outReg <= '0;
    else if (strobes.loadOut) outReg <= compressed;
  end

  assign pSh = outReg;

  // Sum of all nine stored products, used only by the checks below.
  logic [WIDTH-1:0] allProdSum;
  always_comb begin
    allProdSum = '0;
    for (int a = 0; a < NUM_SHARES; a++)
      for (int b = 0; b < NUM_SHARES; b++)
        allProdSum = allProdSum ^ prodReg[a][b];
  end

  // R2: the masks cancel when the output shares are recombined
  p_recombine_r2: assert property (@(posedge clk) disable iff (rst)
    strobes.loadOut |=> ((pSh[0] ^ pSh[1] ^ pSh[2]) == $past(allProdSum)));

  // R6: output shares are held when no result is loaded
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadOut |=> $stable(pSh));

endmodule

// File: rtl/gf128_masked_mult.sv
module gf128_masked_mult
  import gf128_masked_pkg::*;
#(
  parameter int WIDTH = 128,
  parameter logic [WIDTH-1:0] REDUCE = {8'hE1, {(WIDTH-8){1'b0}}},
  localparam int RND_W = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WIDTH-1:0] xShare0,
  input  logic [WIDTH-1:0] xShare1,
  input  logic [WIDTH-1:0] xShare2,
  input  logic [WIDTH-1:0] yShare0,
  input  logic [WIDTH-1:0] yShare1,
  input  logic [WIDTH-1:0] yShare2,
  input  logic [RND_W-1:0] rnd,
  output logic             outValid,
  output logic [WIDTH-1:0] pShare0,
  output logic [WIDTH-1:0] pShare1,
  output logic [WIDTH-1:0] pShare2
);

  mulStrobes_t                      strobes;
  logic [NUM_SHARES-1:0][WIDTH-1:0] xSh;
  logic [NUM_SHARES-1:0][WIDTH-1:0] ySh;
  logic [NUM_SHARES-1:0][WIDTH-1:0] pSh;

  assign xSh = {xShare2, xShare1, xShare0};
  assign ySh = {yShare2, yShare1, yShare0};

  gf128_masked_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  gf128_masked_dp #(.WIDTH(WIDTH), .REDUCE(REDUCE)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .xSh    (xSh),
    .ySh    (ySh),
    .rnd    (rnd),
    .pSh    (pSh)
  );

  assign pShare0 = pSh[0];
  assign pShare1 = pSh[1];
  assign pShare2 = pSh[2];

  // R1: the cycle after reset carries no result
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && pShare0 == '0 && pShare1 == '0 && pShare2 == '0));

endmodule

// File: tb/sim_gf128_masked_mult.sv
module sim_gf128_masked_mult;

  localparam int CLK_PERIOD = 10;
  localparam int W = 128;
  localparam int TOTAL = 560;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [W-1:0] x0 = '0, x1 = '0, x2 = '0, y0 = '0, y1 = '0, y2 = '0;
  logic [2*W-1:0] rnd = '0;
  logic outValid;
  logic [W-1:0] p0, p1, p2;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf128_masked_mult u0 (
    .clk(clk), .rst(rst), .inValid(inValid),
    .xShare0(x0), .xShare1(x1), .xShare2(x2),
    .yShare0(y0), .yShare1(y1), .yShare2(y2),
    .rnd(rnd), .outValid(outValid),
    .pShare0(p0), .pShare1(p1), .pShare2(p2)
  );

  typedef struct {
    int           due;
    logic [W-1:0] s0, s1, s2, prod;
  } expect_t;

  expect_t pend[$];

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  // Reference: plain polynomial order, full carry-less product, then reduce.
  function automatic logic [W-1:0] refMul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-2:0] full;
    logic [W-1:0] pa, pb;
    pa = rev(a);
    pb = rev(b);
    full = '0;
    for (int i = 0; i < W; i++)
      if (pb[i]) full = full ^ ({{(W-1){1'b0}}, pa} << i);
    for (int d = 2*W-2; d >= W; d--)
      if (full[d]) begin
        full[d]     = 1'b0;
        full[d-W+7] = full[d-W+7] ^ 1'b1;
        full[d-W+2] = full[d-W+2] ^ 1'b1;
        full[d-W+1] = full[d-W+1] ^ 1'b1;
        full[d-W]   = full[d-W]   ^ 1'b1;
      end
    return rev(full[W-1:0]);
  endfunction

  function automatic logic [W-1:0] rand128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] heldS0, heldS1, heldS2;
    logic [W-1:0] X, Y, r0, r1;
    int cyc;
    heldS0 = '0; heldS1 = '0; heldS2 = '0;
    // R1: state during reset
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", W'(outValid), '0);
    check(p0 == '0 && p1 == '0 && p2 == '0, "R1", "shares in reset", p0 ^ p1 ^ p2, '0);
    rst = 1'b0;
    cyc = 0;
    while (cyc < TOTAL + 4) begin
      @(negedge clk);
      cyc++;
      // compare outputs against the model
      if (pend.size() > 0 && pend[0].due == cyc) begin
        expect_t e;
        e = pend.pop_front();
        check(outValid == 1'b1, "R3", "outValid on due cycle", W'(outValid), W'(1));
        check(p0 == e.s0 && p1 == e.s1 && p2 == e.s2, "R5", "share0 composition", p0, e.s0);
        check((p0 ^ p1 ^ p2) == e.prod, "R2", "recombined product", p0 ^ p1 ^ p2, e.prod);
        heldS0 = e.s0; heldS1 = e.s1; heldS2 = e.s2;
      end else begin
        check(outValid == 1'b0, "R3", "outValid off cycle", W'(outValid), '0);
        check(p0 == heldS0 && p1 == heldS1 && p2 == heldS2, "R6", "held shares",
              p0 ^ p1 ^ p2, heldS0 ^ heldS1 ^ heldS2);
      end
      if (cyc == 1) begin
        // R1: first cycle after reset already compared above as an off cycle
      end
      // drive next inputs
      if (cyc >= TOTAL) begin
        inValid = 1'b0;
      end else begin
        if (cyc < 150)      inValid = ($urandom % 10) < 7;
        else if (cyc < 260) inValid = 1'b1;             // R4 stream
        else if (cyc < 460) inValid = ($urandom % 4) != 0;
        else if (cyc < 500) inValid = 1'b0;             // R6 long idle
        else                inValid = 1'b1;
        X = rand128();
        Y = rand128();
        if (cyc >= 300 && cyc < 340) X = '0;                      // R7 zero
        if (cyc >= 340 && cyc < 380) X = {1'b1, {(W-1){1'b0}}};   // R7 identity
        if (cyc >= 380 && cyc < 420) Y = '1;
        if (cyc >= 420 && cyc < 440) begin X = '1; Y = '1; end
        x0 = rand128(); x1 = rand128(); x2 = X ^ x0 ^ x1;
        y0 = rand128(); y1 = rand128(); y2 = Y ^ y0 ^ y1;
        r0 = rand128(); r1 = rand128();
        rnd = {r1, r0};
        if (inValid) begin
          expect_t e;
          e.due = cyc + 2;
          e.s0 = refMul(x0, y0) ^ refMul(x0, y1) ^ refMul(x1, y0) ^ r0;
          e.s1 = refMul(x1, y1) ^ refMul(x1, y2) ^ refMul(x2, y1) ^ r1;
          e.s2 = refMul(x2, y2) ^ refMul(x2, y0) ^ refMul(x0, y2) ^ r0 ^ r1;
          e.prod = refMul(X, Y);
          // R7: zero and identity operands have known products
          if (cyc >= 300 && cyc < 340) e.prod = '0;
          if (cyc >= 340 && cyc < 380) e.prod = Y;
          pend.push_back(e);
        end
      end
    end
    check(pend.size() == 0, "R4", "results outstanding", W'(pend.size()), '0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule